// File: doc/BRIEF.md
# PHY lane override sequencer

This block drives the fix-up that follows a link reset on one lane of a four-lane combined serial PHY. It has no path of its own to the PHY's control registers. It issues one register read or write at a time to an indirect access master and waits for each read to return.

An override command runs the full sequence:

1. Wait until the lane has left half-rate signalling.
2. Take control of the receive path and force the receive DPLL mode.
3. Pulse the DPLL reset.
4. Wait a programmable settle time.
5. Optionally take control of the transmit path and load an attenuation code.

A second, shorter command only hands receive control back to the PHY. Each change to a control register is a read of the lane's status register followed by a series of writes. Every write is the previous value with one edit applied, so the enable bit is always toggled before the fields it guards are changed.

The lane number and the attenuation code are captured when a command is accepted. A configuration input says whether the selected lane exists. A command for a missing lane completes at once without touching the bus.

Top module: `lane_ovr_seq`

## Requirements
- R1: After reset, `busy`, `done` and `req_valid` are all low.
- R2: Once `req_valid` is high it stays high, with `req_write`, `req_addr` and `req_wdata` unchanged, until the cycle in which `req_ready` is high. Each read waits for its `rsp_valid` before the next request is made.
- R3: The lane's register addresses are formed as follows. Transmit status is at 0x2001 + 0x100·lane and receive status at 0x2002 + 0x100·lane. Transmit control is at 0x2004 + 0x100·lane and receive control at 0x2005 + 0x100·lane. Reads go only to the two status registers and writes go only to the two control registers.
- R4: An override first reads receive status again while its bit 0 (half-rate) returns 1. After POLL_MAX such reads it moves on whatever bit 0 shows.
- R5: The override then makes one more read of receive status, with result S. It writes receive control five times, in this order:
  - S with bit 14 cleared;
  - that value with bit 14 set;
  - that value with bits 10:8 replaced by 3;
  - that value with bit 11 set;
  - that value with bit 11 cleared.
- R6: The next request of the override, the transmit status read, is presented SETTLE_CYCLES clock cycles after the edge that accepts the fifth receive control write.
- R7: When bit 3 of the attenuation code is 0, the override reads transmit status, with result T. It then writes transmit control three times:
  - T with bit 15 cleared;
  - that value with bit 15 set;
  - that value ORed with attenuation bits 2:0 placed at bits 12:10.
- R8: When bit 3 of the attenuation code is 1, the transmit step makes no access. `done` then rises SETTLE_CYCLES cycles after the edge that accepts the fifth receive control write.
- R9: A disable command reads receive status, with result S. It writes S with bit 14 cleared to receive control and then completes.
- R10: When `lane_present` is low at the start, the command completes with `done` in the cycle after the start and makes no request.
- R11: `done` is a one-cycle pulse in the cycle after the edge that accepts a command's last write. `busy` is high from the cycle after the start through the `done` cycle and low after it.
- R12: If both starts are high in the same cycle while idle, the override runs. Starts while busy are ignored, and so are changes of `lane_sel` and `atten` after a command has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_override | input | 1 | Start the full override sequence |
| start_disable | input | 1 | Start the receive-control release |
| lane_present | input | 1 | Selected lane is configured |
| lane_sel | input | 2 | Lane number 0 to 3 |
| atten | input | 4 | Attenuation code; bit 3 set skips the transmit step |
| req_valid | output | 1 | Register access request pending |
| req_ready | input | 1 | Access master takes the request this cycle |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | 16 | Register address |
| req_wdata | output | 16 | Write data |
| rsp_valid | input | 1 | Read data returned |
| rsp_data | input | 16 | Read data |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The override and the disable command share one start decoder, so the two can be requested in the same cycle. The bench raises both starts together while idle. It judges the result by the access trace, which must match the full override chain and not the short read-write pair of a disable. It also pulses a disable start, and changes the lane and attenuation inputs, while an override is mid-sequence. The trace must still be exactly the override computed for the values captured at the start, with the expected settle spacing and `done` timing.

// File: rtl/lane_ovr_pkg.sv
package lane_ovr_pkg;

  localparam int CR_ADDR_W = 16;
  localparam int CR_DATA_W = 16;
  localparam int STEP_W    = 3;

  localparam logic [CR_ADDR_W-1:0] TX_STS_BASE = 16'h2001;
  localparam logic [CR_ADDR_W-1:0] RX_STS_BASE = 16'h2002;
  localparam logic [CR_ADDR_W-1:0] TX_CTL_BASE = 16'h2004;
  localparam logic [CR_ADDR_W-1:0] RX_CTL_BASE = 16'h2005;

  localparam logic [CR_DATA_W-1:0] RX_OWN_BIT   = 16'h4000;
  localparam logic [CR_DATA_W-1:0] TX_OWN_BIT   = 16'h8000;
  localparam logic [CR_DATA_W-1:0] DPLL_RST_BIT = 16'h0800;
  localparam logic [CR_DATA_W-1:0] DPLL_MODE_MSK = 16'h0700;
  localparam int                   DPLL_MODE_LSB = 8;
  localparam logic [2:0]           DPLL_MODE_FORCED = 3'd3;
  localparam int                   ATTN_LSB      = 10;

  localparam logic [STEP_W-1:0] RX_LAST_STEP = 3'd4;
  localparam logic [STEP_W-1:0] TX_LAST_STEP = 3'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_POLL_RD, S_POLL_WT, S_STS_RD, S_STS_WT, S_RX_WR, S_SETTLE,
    S_TX_RD, S_TX_WT, S_TX_WR, S_DIS_RD, S_DIS_WT, S_DIS_WR, S_FIN
  } seq_state_e;

  // Register address of one lane: 0x100 per lane above the base.
  function automatic logic [CR_ADDR_W-1:0] lane_addr(
      input logic [CR_ADDR_W-1:0] base, input logic [3:0] lane);
    return base + {4'h0, lane, 8'h00};
  endfunction

  // Receive control chain: each step edits the previous written value.
  function automatic logic [CR_DATA_W-1:0] rx_edit(
      input logic [CR_DATA_W-1:0] v, input logic [STEP_W-1:0] step);
    case (step)
      3'd0:    return v & ~RX_OWN_BIT;
      3'd1:    return v | RX_OWN_BIT;
      3'd2:    return (v & ~DPLL_MODE_MSK) |
                      ({13'd0, DPLL_MODE_FORCED} << DPLL_MODE_LSB);
      3'd3:    return v | DPLL_RST_BIT;
      default: return v & ~DPLL_RST_BIT;
    endcase
  endfunction

  // Transmit control chain.
  function automatic logic [CR_DATA_W-1:0] tx_edit(
      input logic [CR_DATA_W-1:0] v, input logic [STEP_W-1:0] step,
      input logic [2:0] fld);
    case (step)
      3'd0:    return v & ~TX_OWN_BIT;
      3'd1:    return v | TX_OWN_BIT;
      default: return v | ({13'd0, fld} << ATTN_LSB);
    endcase
  endfunction

endpackage

// File: rtl/lane_ovr_count.sv
module lane_ovr_count #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic hit
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clr)            cnt <= '0;
    else if (inc && !hit)    cnt <= cnt + CW'(1);
  end

  assign hit = (cnt == LAST);
endmodule

// File: rtl/lane_ovr_req_gen.sv
module lane_ovr_req_gen
  import lane_ovr_pkg::*;
#(
  parameter int LANE_W = 2
) (
  input  seq_state_e              state,
  input  logic [STEP_W-1:0]       step,
  input  logic [CR_DATA_W-1:0]    work,
  input  logic [LANE_W-1:0]       lane,
  input  logic [2:0]              attn_fld,
  output logic                    req_valid,
  output logic                    req_write,
  output logic [CR_ADDR_W-1:0]    req_addr,
  output logic [CR_DATA_W-1:0]    req_wdata
);
  logic [3:0] lane4;
  assign lane4 = 4'(lane);

  always_comb begin
    req_valid = 1'b0;
    req_write = 1'b0;
    req_addr  = lane_addr(RX_STS_BASE, lane4);
    req_wdata = '0;
    case (state)
      S_POLL_RD, S_STS_RD, S_DIS_RD: begin
        req_valid = 1'b1;
      end
      S_TX_RD: begin
        req_valid = 1'b1;
        req_addr  = lane_addr(TX_STS_BASE, lane4);
      end
      S_RX_WR: begin
        req_valid = 1'b1;
        req_write = 1'b1;
        req_addr  = lane_addr(RX_CTL_BASE, lane4);
        req_wdata = rx_edit(work, step);
      end
      S_DIS_WR: begin
        req_valid = 1'b1;
        req_write = 1'b1;
        req_addr  = lane_addr(RX_CTL_BASE, lane4);
        req_wdata = rx_edit(work, 3'd0);
      end
      S_TX_WR: begin
        req_valid = 1'b1;
        req_write = 1'b1;
        req_addr  = lane_addr(TX_CTL_BASE, lane4);
        req_wdata = tx_edit(work, step, attn_fld);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lane_ovr_fsm.sv
module lane_ovr_fsm
  import lane_ovr_pkg::*;
#(
  parameter int LANE_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_override,
  input  logic                 start_disable,
  input  logic                 lane_present,
  input  logic [LANE_W-1:0]    lane_sel,
  input  logic [3:0]           atten,
  input  logic                 req_fire,
  input  logic [CR_DATA_W-1:0] wr_data,
  input  logic                 rsp_valid,
  input  logic [CR_DATA_W-1:0] rsp_data,
  input  logic                 poll_hit,
  input  logic                 settle_hit,
  output seq_state_e           state,
  output logic [STEP_W-1:0]    step,
  output logic [CR_DATA_W-1:0] work,
  output logic [LANE_W-1:0]    lane_q,
  output logic [2:0]           attn_fld,
  output logic                 ev_accept_ovr,
  output logic                 ev_accept_dis,
  output logic                 ev_unconf
);
  logic [3:0] attn_q;

  assign ev_accept_ovr = (state == S_IDLE) && start_override;
  assign ev_accept_dis = (state == S_IDLE) && !start_override && start_disable;
  assign ev_unconf     = (ev_accept_ovr || ev_accept_dis) && !lane_present;
  assign attn_fld      = attn_q[2:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      step   <= '0;
      work   <= '0;
      lane_q <= '0;
      attn_q <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (ev_accept_ovr || ev_accept_dis) begin
            lane_q <= lane_sel;
            attn_q <= atten;
            if (!lane_present)      state <= S_FIN;
            else if (ev_accept_ovr) state <= S_POLL_RD;
            else                    state <= S_DIS_RD;
          end
        end
        S_POLL_RD: if (req_fire) state <= S_POLL_WT;
        S_POLL_WT: begin
          if (rsp_valid) begin
            if (rsp_data[0] && !poll_hit) state <= S_POLL_RD;
            else                          state <= S_STS_RD;
          end
        end
        S_STS_RD: if (req_fire) state <= S_STS_WT;
        S_STS_WT: begin
          if (rsp_valid) begin
            work  <= rsp_data;
            step  <= '0;
            state <= S_RX_WR;
          end
        end
        S_RX_WR: begin
          if (req_fire) begin
            work <= wr_data;
            if (step == RX_LAST_STEP) state <= S_SETTLE;
            else                      step  <= step + 3'd1;
          end
        end
        S_SETTLE: begin
          if (settle_hit) state <= attn_q[3] ? S_FIN : S_TX_RD;
        end
        S_TX_RD: if (req_fire) state <= S_TX_WT;
        S_TX_WT: begin
          if (rsp_valid) begin
            work  <= rsp_data;
            step  <= '0;
            state <= S_TX_WR;
          end
        end
        S_TX_WR: begin
          if (req_fire) begin
            work <= wr_data;
            if (step == TX_LAST_STEP) state <= S_FIN;
            else                      step  <= step + 3'd1;
          end
        end
        S_DIS_RD: if (req_fire) state <= S_DIS_WT;
        S_DIS_WT: begin
          if (rsp_valid) begin
            work  <= rsp_data;
            state <= S_DIS_WR;
          end
        end
        S_DIS_WR: if (req_fire) state <= S_FIN;
        default:  state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lane_ovr_seq.sv
module lane_ovr_seq
  import lane_ovr_pkg::*;
#(
  parameter int LANES         = 4,
  parameter int POLL_MAX      = 1000,
  parameter int SETTLE_CYCLES = 1500000,
  localparam int LANE_W       = $clog2(LANES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_override,
  input  logic                 start_disable,
  input  logic                 lane_present,
  input  logic [LANE_W-1:0]    lane_sel,
  input  logic [3:0]           atten,
  output logic                 req_valid,
  input  logic                 req_ready,
  output logic                 req_write,
  output logic [CR_ADDR_W-1:0] req_addr,
  output logic [CR_DATA_W-1:0] req_wdata,
  input  logic                 rsp_valid,
  input  logic [CR_DATA_W-1:0] rsp_data,
  output logic                 busy,
  output logic                 done
);
  seq_state_e           state;
  logic [STEP_W-1:0]    step;
  logic [CR_DATA_W-1:0] work;
  logic [LANE_W-1:0]    lane_q;
  logic [2:0]           attn_fld;
  logic                 ev_accept_ovr, ev_accept_dis, ev_unconf;
  logic                 req_fire;
  logic                 poll_hit, settle_hit;
  logic                 poll_clr, poll_inc, settle_clr, settle_inc;

  assign req_fire   = req_valid && req_ready;
  assign poll_clr   = (state != S_POLL_RD) && (state != S_POLL_WT);
  assign poll_inc   = (state == S_POLL_WT) && rsp_valid;
  assign settle_clr = (state != S_SETTLE);
  assign settle_inc = (state == S_SETTLE);
  assign busy       = (state != S_IDLE);
  assign done       = (state == S_FIN);

  lane_ovr_fsm #(.LANE_W(LANE_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .start_override(start_override), .start_disable(start_disable),
    .lane_present(lane_present), .lane_sel(lane_sel), .atten(atten),
    .req_fire(req_fire), .wr_data(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .poll_hit(poll_hit), .settle_hit(settle_hit),
    .state(state), .step(step), .work(work), .lane_q(lane_q),
    .attn_fld(attn_fld), .ev_accept_ovr(ev_accept_ovr),
    .ev_accept_dis(ev_accept_dis), .ev_unconf(ev_unconf)
  );

  lane_ovr_req_gen #(.LANE_W(LANE_W)) u_req (
    .state(state), .step(step), .work(work), .lane(lane_q),
    .attn_fld(attn_fld), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata)
  );

  lane_ovr_count #(.LIMIT(POLL_MAX)) u_poll_cnt (
    .clk(clk), .rst_n(rst_n), .clr(poll_clr), .inc(poll_inc), .hit(poll_hit)
  );

  lane_ovr_count #(.LIMIT(SETTLE_CYCLES)) u_settle_cnt (
    .clk(clk), .rst_n(rst_n), .clr(settle_clr), .inc(settle_inc),
    .hit(settle_hit)
  );
endmodule

// File: rtl/lane_ovr_chk.sv
module lane_ovr_chk #(
  parameter int LANE_W   = 2,
  parameter int POLL_MAX = 1000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [15:0]       req_addr,
  input logic [15:0]       req_wdata,
  input logic              busy,
  input logic              done,
  input logic              lane_present,
  input logic              ev_accept_ovr,
  input logic              ev_accept_dis,
  input logic              ev_unconf,
  input logic [LANE_W-1:0] lane_q
);
  localparam int RC_W = $clog2(POLL_MAX + 3);

  logic [RC_W-1:0] rx_rd_cnt;
  logic            seen_write;
  logic            rx_sts_fire;

  assign rx_sts_fire = req_valid && req_ready && !req_write &&
                       (req_addr[7:0] == 8'h02);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_rd_cnt  <= '0;
      seen_write <= 1'b0;
    end else if (ev_accept_ovr || ev_accept_dis) begin
      rx_rd_cnt  <= '0;
      seen_write <= 1'b0;
    end else begin
      if (req_valid && req_ready && req_write) seen_write <= 1'b1;
      if (rx_sts_fire && !seen_write && rx_rd_cnt != '1)
        rx_rd_cnt <= rx_rd_cnt + RC_W'(1);
    end
  end

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) &&
      $stable(req_wdata) && $stable(req_write));

  assert_addr_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_addr[15:10] == 6'b001000) &&
      (req_addr[8 +: LANE_W] == lane_q));

  assert_rd_wr_kind_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_write ? (req_addr[7:0] == 8'h04 || req_addr[7:0] == 8'h05)
                             : (req_addr[7:0] == 8'h01 || req_addr[7:0] == 8'h02)));

  assert_poll_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd_cnt <= RC_W'(POLL_MAX + 1));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid);

  assert_unconf_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_unconf |=> done && !req_valid);

  assert_accept_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept_ovr || ev_accept_dis) && lane_present |=> busy && !done);
endmodule

bind lane_ovr_seq lane_ovr_chk #(.LANE_W(LANE_W), .POLL_MAX(POLL_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
  .busy(busy), .done(done), .lane_present(lane_present),
  .ev_accept_ovr(ev_accept_ovr), .ev_accept_dis(ev_accept_dis),
  .ev_unconf(ev_unconf), .lane_q(lane_q)
);

// File: tb/test_lane_ovr_seq.sv
module test_lane_ovr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int POLL_MAX   = 6;
  localparam int SETTLE     = 25;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst_n, start_override, start_disable, lane_present;
  logic [1:0]  lane_sel;
  logic [3:0]  atten;
  logic        req_valid, req_ready, req_write, rsp_valid, busy, done;
  logic [15:0] req_addr, req_wdata, rsp_data;

  lane_ovr_seq #(.POLL_MAX(POLL_MAX), .SETTLE_CYCLES(SETTLE)) i_lane_ovr_seq (
    .clk(clk), .rst_n(rst_n), .start_override(start_override),
    .start_disable(start_disable), .lane_present(lane_present),
    .lane_sel(lane_sel), .atten(atten), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .busy(busy), .done(done)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // access master model and trace
  int log_addr[64], log_data[64], log_wr[64], log_pres[64], log_acc[64];
  int log_n = 0;
  int m_ones = 0, m_rx = 0, m_tx = 0;
  bit m_stall = 0, stall_tog = 0, rsp_pend = 0, pres_pend = 0;
  int rsp_pend_data = 0, pres_edge = 0;

  initial begin
    req_ready = 0; rsp_valid = 0; rsp_data = 0;
    forever begin
      @(negedge clk);
      rsp_valid = 0;
      if (rsp_pend) begin
        rsp_valid = 1; rsp_data = rsp_pend_data[15:0]; rsp_pend = 0;
      end
      req_ready = 0;
      if (rst_n && req_valid) begin
        int d;
        if (!pres_pend) begin pres_pend = 1; pres_edge = cyc; end
        stall_tog = !stall_tog;
        if (!m_stall || stall_tog) begin
          req_ready = 1; pres_pend = 0;
          if (req_write) d = req_wdata;
          else if (req_addr[7:0] == 8'h02) begin
            if (m_ones > 0) begin d = m_rx | 1; m_ones--; end
            else d = m_rx & 'hFFFE;
          end else d = m_tx;
          if (!req_write) begin rsp_pend = 1; rsp_pend_data = d; end
          if (log_n < 64) begin
            log_addr[log_n] = req_addr; log_data[log_n] = d;
            log_wr[log_n] = req_write; log_pres[log_n] = pres_edge;
            log_acc[log_n] = cyc + 1;
            log_n++;
          end
        end
      end
    end
  end

  function automatic int la(input int i); return (i < log_n) ? log_addr[i] : -1; endfunction
  function automatic int ld(input int i); return (i < log_n) ? log_data[i] : -1; endfunction
  function automatic int lw(input int i); return (i < log_n) ? log_wr[i] : -1; endfunction

  task automatic wait_done(output int de);
    bit got = 0;
    de = -1;
    for (int i = 0; i < 20000 && !got; i++) begin
      @(negedge clk);
      if (done) begin de = cyc; got = 1; end
    end
    chk("R11 done seen", got, 1);
  endtask

  task automatic after_done();
    @(negedge clk);
    chk("R11 done one cycle", done, 0);
    chk("R11 busy low after done", busy, 0);
  endtask

  task automatic t_reset();
    rst_n = 0; start_override = 0; start_disable = 0; lane_present = 1;
    lane_sel = 0; atten = 0;
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 req_valid", req_valid, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R1 idle after release", req_valid, 0);
  endtask

  task automatic t_override(input int lane, input int at, input int ones,
                            input int rxv, input int txv, input bit stall,
                            input bit both, input bit poke);
    int de, np, i, s, t, exp_len, last_rx;
    int rx_exp[5], tx_exp[3];
    log_n = 0; m_ones = ones; m_rx = rxv; m_tx = txv; m_stall = stall;
    @(negedge clk);
    lane_sel = lane[1:0]; atten = at[3:0]; lane_present = 1;
    start_override = 1; start_disable = both;
    @(negedge clk);
    start_override = 0; start_disable = 0;
    if (poke) begin
      repeat (2) @(negedge clk);
      start_disable = 1; lane_sel = lane[1:0] ^ 2'b01; atten = ~at[3:0];
      @(negedge clk);
      start_disable = 0;
    end
    wait_done(de);
    after_done();
    np = (ones >= POLL_MAX) ? POLL_MAX : ones + 1;
    exp_len = np + 6 + (at[3] ? 0 : 4);
    chk("R12 R8 trace length", log_n, exp_len);
    for (i = 0; i < np; i++) begin
      chk("R4 poll read addr", la(i), 'h2002 + lane * 'h100);
      chk("R4 poll is read", lw(i), 0);
    end
    chk("R3 status read addr", la(np), 'h2002 + lane * 'h100);
    s = ld(np);
    rx_exp[0] = s & ~'h4000;
    rx_exp[1] = rx_exp[0] | 'h4000;
    rx_exp[2] = (rx_exp[1] & ~'h0700) | 'h0300;
    rx_exp[3] = rx_exp[2] | 'h0800;
    rx_exp[4] = rx_exp[3] & ~'h0800;
    for (i = 0; i < 5; i++) begin
      chk("R3 rx ctl addr", la(np + 1 + i), 'h2005 + lane * 'h100);
      chk("R5 rx ctl data", ld(np + 1 + i), rx_exp[i]);
    end
    last_rx = np + 5;
    if (!at[3]) begin
      chk("R6 settle spacing", (last_rx + 1 < log_n) ? log_pres[last_rx + 1] - log_acc[last_rx] : -1, SETTLE);
      chk("R7 tx status addr", la(last_rx + 1), 'h2001 + lane * 'h100);
      chk("R7 tx status read", lw(last_rx + 1), 0);
      t = ld(last_rx + 1);
      tx_exp[0] = t & ~'h8000;
      tx_exp[1] = tx_exp[0] | 'h8000;
      tx_exp[2] = tx_exp[1] | ((at & 7) << 10);
      for (i = 0; i < 3; i++) begin
        chk("R7 tx ctl addr", la(last_rx + 2 + i), 'h2004 + lane * 'h100);
        chk("R7 tx ctl data", ld(last_rx + 2 + i), tx_exp[i]);
      end
      chk("R11 done after last write", de, (log_n > 0) ? log_acc[log_n - 1] : -1);
    end else begin
      chk("R8 done after settle", (last_rx < log_n) ? de - log_acc[last_rx] : -1, SETTLE);
    end
  endtask

  task automatic t_disable(input int lane, input int rxv, input bit stall);
    int de;
    log_n = 0; m_ones = 0; m_rx = rxv; m_stall = stall;
    @(negedge clk);
    lane_sel = lane[1:0]; lane_present = 1; start_disable = 1;
    @(negedge clk);
    start_disable = 0;
    wait_done(de);
    after_done();
    chk("R9 trace length", log_n, 2);
    chk("R9 read addr", la(0), 'h2002 + lane * 'h100);
    chk("R9 is read", lw(0), 0);
    chk("R9 write addr", la(1), 'h2005 + lane * 'h100);
    chk("R9 write data", ld(1), ld(0) & ~'h4000);
    chk("R11 done after disable write", de, (log_n > 1) ? log_acc[1] : -1);
  endtask

  task automatic t_unconf(input bit ovr);
    int de, se;
    log_n = 0; m_stall = 0;
    @(negedge clk);
    lane_present = 0; lane_sel = 2; atten = 4'h1;
    start_override = ovr; start_disable = !ovr; se = cyc + 1;
    @(negedge clk);
    start_override = 0; start_disable = 0;
    chk("R10 done next cycle", done, 1);
    de = done ? cyc : -1;
    chk("R10 done edge", de, se);
    after_done();
    chk("R10 no request", log_n, 0);
    lane_present = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_override(0, 5, 0, 'h1234, 'h0000, 0, 0, 0);
    t_override(2, 3, 3, 'h4F0F, 'h83A1, 1, 0, 0);
    t_override(3, 'hA, 10, 'hBEEF, 'h0000, 0, 0, 0);   // R4 limit, R8 skip
    t_override(1, 9, 1, 'h0C70, 'h1111, 1, 0, 0);      // R8 skip with stall
    t_disable(1, 'hC001, 0);
    t_disable(3, 'h7FFF, 1);
    t_unconf(1);
    t_unconf(0);
    t_override(2, 7, 2, 'h0A55, 'h5C00, 0, 1, 1);      // R12 both starts, poke
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule